// File: doc/BRIEF.md
# Pin Function Multiplexer Controller

This block chooses which peripheral function drives each device terminal. It holds a bank of 32-bit select registers. Each 8-bit lane of a register belongs to one terminal, so one register covers four terminals. The low `SEL_W` bits of a lane form a one-hot choice among that terminal's functions. Bit 0 is the terminal's default function. When a lane holds no set bit, or more than one set bit, the terminal falls back to the default function. The chosen function then drives every control of the terminal's output buffer: data, active-low enable, drive strength and slew rate.

Software reaches the select registers through a simple register bus. Reads are allowed in any mode. A write takes effect only when it is a privileged access. Writes to the select registers also need an unlock: two key registers must both hold their fixed unlock words. A discarded write sets a sticky error flag and raises a one-cycle error pulse. The flag is cleared by writing 1 to it.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset, every select register reads 32'h01010101 and every terminal outputs its function 0. Both key registers read 0, the block is locked, the status bit reads 0 and `err_pulse` is 0.
- R2: Terminal p is controlled by bits [8p+7:8p] of the flat select space. That is lane p mod 4 of the select register at word address 4 + p/4. When exactly one of lane bits 0..SEL_W-1 is set, at bit k, the terminal outputs function k.
- R3: When lane bits 0..SEL_W-1 are all clear, the terminal outputs function 0.
- R4: When two or more of lane bits 0..SEL_W-1 are set, the terminal outputs function 0.
- R5: The selected function supplies all four buffer controls of its terminal. These are data, `oe_n`, drive and slew, taken from bit p*SEL_W+k of the matching `func_*` input.
- R6: Lane bits SEL_W..7 always read 0, and writes to them have no effect.
- R7: A select-register write takes effect only while key register 0 (word address 0) holds KEY0 and key register 1 (word address 1) holds KEY1. A privileged write of any other value to either key relocks the block.
- R8: A write with `bus_priv`=0 is discarded at every address, including the key and status registers.
- R9: A violating write sets status bit 0 (word address 2) and drives `err_pulse` high for exactly the following cycle. A violating write is a user-mode write, or a privileged select-register write while locked.
- R10: A privileged write to the status word with bit 0 set clears the status bit. Writing 0 to that bit leaves it unchanged.
- R11: Reads are combinational and independent of `bus_priv`. `bus_rdata` returns the key, status or select register at `bus_addr`, and 0 for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = privileged access |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| err_pulse | output | 1 | One-cycle pulse after a violating write |
| func_data | input | NUM_REGS*4*SEL_W | Data-out of each function of each terminal |
| func_oe_n | input | NUM_REGS*4*SEL_W | Active-low output enable of each function |
| func_drive | input | NUM_REGS*4*SEL_W | Drive-strength select of each function |
| func_slew | input | NUM_REGS*4*SEL_W | Slew-rate select of each function |
| pad_data | output | NUM_REGS*4 | Data to each terminal buffer |
| pad_oe_n | output | NUM_REGS*4 | Active-low enable to each terminal buffer |
| pad_drive | output | NUM_REGS*4 | Drive-strength select to each terminal buffer |
| pad_slew | output | NUM_REGS*4 | Slew-rate select to each terminal buffer |

## Verification
The assertions assume that the bus makes at most one access per cycle. They also assume that `bus_sel`, `bus_wr` and `bus_priv` are known 0 or 1 whenever reset is low, and that the function inputs are stable between clock edges. The stimulus meets these conditions in the following way. It changes every input only at the falling edge and holds each write for one cycle. It idles the bus with `bus_sel` low between accesses. It also keeps the function vectors constant during each sweep pass.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

    localparam int LANE_W         = 8;
    localparam int WORD_W         = 32;
    localparam int LANES_PER_WORD = WORD_W / LANE_W;

    localparam int ADDR_KEY0     = 0;
    localparam int ADDR_KEY1     = 1;
    localparam int ADDR_STAT     = 2;
    localparam int ADDR_MUX_BASE = 4;

    typedef struct packed {
        logic data;
        logic oe_n;
        logic drive;
        logic slew;
    } pad_ctl_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_KEY0,
        TGT_KEY1,
        TGT_STAT,
        TGT_MUX
    } target_t;

    // Writable bits of one lane: the select field only.
    function automatic logic [LANE_W-1:0] lane_mask(input int nsel);
        logic [LANE_W-1:0] m;
        m = '0;
        for (int k = 0; k < LANE_W; k++)
            if (k < nsel) m[k] = 1'b1;
        return m;
    endfunction

    // One-hot select to function index; zero or several bits give function 0.
    function automatic int lane_pick(input logic [LANE_W-1:0] lane, input int nsel);
        int cnt;
        int idx;
        cnt = 0;
        idx = 0;
        for (int k = 0; k < LANE_W; k++) begin
            if (k < nsel && lane[k]) begin
                cnt = cnt + 1;
                idx = k;
            end
        end
        return (cnt == 1) ? idx : 0;
    endfunction

    function automatic logic [WORD_W-1:0] word_reset_value();
        logic [WORD_W-1:0] w;
        for (int l = 0; l < LANES_PER_WORD; l++)
            w[l*LANE_W +: LANE_W] = LANE_W'(1);
        return w;
    endfunction

endpackage

// File: rtl/pinmux_kicker.sv
module pinmux_kicker #(
    parameter logic [31:0] KEY0 = 32'h83E7_0B13,
    parameter logic [31:0] KEY1 = 32'h95A4_F1E0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_key0,
    input  logic        wr_key1,
    input  logic [31:0] wdata,
    output logic [31:0] key0_q,
    output logic [31:0] key1_q,
    output logic        unlocked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            key0_q <= '0;
            key1_q <= '0;
        end else begin
            if (wr_key0) key0_q <= wdata;
            if (wr_key1) key1_q <= wdata;
        end
    end

    assign unlocked = (key0_q == KEY0) && (key1_q == KEY1);

    assert_relock0_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_key0 && wdata != KEY0) |=> !unlocked);

    assert_relock1_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_key1 && wdata != KEY1) |=> !unlocked);

endmodule

// File: rtl/pinmux_regbank.sv
module pinmux_regbank
    import pinmux_pkg::*;
#(
    parameter int NUM_REGS = 2,
    parameter int SEL_W    = 3,
    localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [WORD_W-1:0]          wr_data,
    output logic [NUM_REGS*WORD_W-1:0] regs_flat
);

    localparam logic [LANE_W-1:0] LMASK = lane_mask(SEL_W);
    localparam logic [WORD_W-1:0] RSTV  = word_reset_value();

    logic [WORD_W-1:0] regs_q [NUM_REGS];
    logic [WORD_W-1:0] wmask;

    always_comb begin
        for (int l = 0; l < LANES_PER_WORD; l++)
            wmask[l*LANE_W +: LANE_W] = LMASK;
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[r] <= RSTV;
            else if (wr_en && wr_idx == IDX_W'(r))
                regs_q[r] <= wr_data & wmask;
        end

        assign regs_flat[r*WORD_W +: WORD_W] = regs_q[r];

        assert_hold_when_blocked_R7: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && wr_idx == IDX_W'(r)) |=> $stable(regs_q[r]));

        assert_unused_zero_R6: assert property (@(posedge clk) disable iff (rst)
            (regs_q[r] & ~wmask) == '0);
    end

endmodule

// File: rtl/pinmux_lane_mux.sv
module pinmux_lane_mux
    import pinmux_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] lane,
    input  logic [SEL_W-1:0]  fn_data,
    input  logic [SEL_W-1:0]  fn_oe_n,
    input  logic [SEL_W-1:0]  fn_drive,
    input  logic [SEL_W-1:0]  fn_slew,
    output pad_ctl_t          pad
);

    int sel_idx;

    always_comb begin
        sel_idx    = lane_pick(lane, SEL_W);
        pad.data   = fn_data[sel_idx];
        pad.oe_n   = fn_oe_n[sel_idx];
        pad.drive  = fn_drive[sel_idx];
        pad.slew   = fn_slew[sel_idx];
    end

    assert_fallback_default_R4: assert property (@(posedge clk) disable iff (rst)
        ($countones(lane[SEL_W-1:0]) != 1) |->
            (pad.data == fn_data[0] && pad.oe_n == fn_oe_n[0] &&
             pad.drive == fn_drive[0] && pad.slew == fn_slew[0]));

    assert_onehot_path_R5: assert property (@(posedge clk) disable iff (rst)
        ($countones(lane[SEL_W-1:0]) == 1 && lane[SEL_W-1]) |->
            (pad.data == fn_data[SEL_W-1] && pad.oe_n == fn_oe_n[SEL_W-1]));

endmodule

// File: rtl/pinmux_ctrl.sv
module pinmux_ctrl
    import pinmux_pkg::*;
#(
    parameter int          NUM_REGS = 2,
    parameter int          SEL_W    = 3,
    parameter logic [31:0] KEY0     = 32'h83E7_0B13,
    parameter logic [31:0] KEY1     = 32'h95A4_F1E0,
    localparam int NUM_PADS = NUM_REGS * LANES_PER_WORD,
    localparam int NFN      = NUM_PADS * SEL_W,
    localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic                bus_priv,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                err_pulse,
    input  logic [NFN-1:0]      func_data,
    input  logic [NFN-1:0]      func_oe_n,
    input  logic [NFN-1:0]      func_drive,
    input  logic [NFN-1:0]      func_slew,
    output logic [NUM_PADS-1:0] pad_data,
    output logic [NUM_PADS-1:0] pad_oe_n,
    output logic [NUM_PADS-1:0] pad_drive,
    output logic [NUM_PADS-1:0] pad_slew
);

    target_t    tgt;
    logic       wr_any;
    logic       viol;
    logic       unlocked;
    logic       mux_we;
    logic       stat_clr;
    logic       stat_err;
    logic [IDX_W-1:0]           mux_idx;
    logic [31:0]                key0_q, key1_q;
    logic [NUM_PADS*LANE_W-1:0] mux_flat;

    // Address decode
    always_comb begin
        tgt     = TGT_NONE;
        mux_idx = '0;
        if (int'(bus_addr) == ADDR_KEY0)      tgt = TGT_KEY0;
        else if (int'(bus_addr) == ADDR_KEY1) tgt = TGT_KEY1;
        else if (int'(bus_addr) == ADDR_STAT) tgt = TGT_STAT;
        else if (int'(bus_addr) >= ADDR_MUX_BASE &&
                 int'(bus_addr) <  ADDR_MUX_BASE + NUM_REGS) begin
            tgt     = TGT_MUX;
            mux_idx = IDX_W'(int'(bus_addr) - ADDR_MUX_BASE);
        end
    end

    assign wr_any   = bus_sel && bus_wr;
    assign viol     = wr_any && (!bus_priv || (tgt == TGT_MUX && !unlocked));
    assign mux_we   = wr_any && bus_priv && unlocked && tgt == TGT_MUX;
    assign stat_clr = wr_any && bus_priv && tgt == TGT_STAT && bus_wdata[0];

    pinmux_kicker #(.KEY0(KEY0), .KEY1(KEY1)) u_kick (
        .clk      (clk),
        .rst      (rst),
        .wr_key0  (wr_any && bus_priv && tgt == TGT_KEY0),
        .wr_key1  (wr_any && bus_priv && tgt == TGT_KEY1),
        .wdata    (bus_wdata),
        .key0_q   (key0_q),
        .key1_q   (key1_q),
        .unlocked (unlocked)
    );

    pinmux_regbank #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (mux_we),
        .wr_idx    (mux_idx),
        .wr_data   (bus_wdata),
        .regs_flat (mux_flat)
    );

    // Error status
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_err  <= 1'b0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= viol;
            if (viol)          stat_err <= 1'b1;
            else if (stat_clr) stat_err <= 1'b0;
        end
    end

    // Read path
    always_comb begin
        bus_rdata = '0;
        unique case (tgt)
            TGT_KEY0: bus_rdata = key0_q;
            TGT_KEY1: bus_rdata = key1_q;
            TGT_STAT: bus_rdata = {31'b0, stat_err};
            TGT_MUX:  bus_rdata = mux_flat[int'(mux_idx)*WORD_W +: WORD_W];
            default:  bus_rdata = '0;
        endcase
    end

    // Per-terminal selection
    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pad_ctl_t ctl;

        pinmux_lane_mux #(.SEL_W(SEL_W)) u_lane (
            .clk      (clk),
            .rst      (rst),
            .lane     (mux_flat[p*LANE_W +: LANE_W]),
            .fn_data  (func_data [p*SEL_W +: SEL_W]),
            .fn_oe_n  (func_oe_n [p*SEL_W +: SEL_W]),
            .fn_drive (func_drive[p*SEL_W +: SEL_W]),
            .fn_slew  (func_slew [p*SEL_W +: SEL_W]),
            .pad      (ctl)
        );

        assign pad_data[p]  = ctl.data;
        assign pad_oe_n[p]  = ctl.oe_n;
        assign pad_drive[p] = ctl.drive;
        assign pad_slew[p]  = ctl.slew;
    end

    assert_viol_flags_R9: assert property (@(posedge clk) disable iff (rst)
        viol |=> (err_pulse && stat_err));

    assert_pulse_implies_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> stat_err);

    assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !viol) |=> !stat_err);

    assert_user_no_unlock_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_any && !bus_priv) |=> $stable(key0_q) && $stable(key1_q));

endmodule

// File: tb/sim_pinmux_ctrl.sv
module sim_pinmux_ctrl;

    localparam int NUM_REGS = 2;
    localparam int SEL_W    = 3;
    localparam int NP       = NUM_REGS * 4;
    localparam int NF       = NP * SEL_W;
    localparam logic [31:0] K0 = 32'h83E7_0B13;
    localparam logic [31:0] K1 = 32'h95A4_F1E0;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_pulse;
    logic [NF-1:0] fd = '0, fo = '0, fdr = '0, fs = '0;
    logic [NP-1:0] pd, po, pdr, ps;

    int checks = 0;
    int failures = 0;
    logic [31:0] model [NUM_REGS];

    always #5 clk = ~clk;

    pinmux_ctrl #(.NUM_REGS(NUM_REGS), .SEL_W(SEL_W), .KEY0(K0), .KEY1(K1)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_priv(bus_priv),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_pulse(err_pulse), .func_data(fd), .func_oe_n(fo), .func_drive(fdr),
        .func_slew(fs), .pad_data(pd), .pad_oe_n(po), .pad_drive(pdr), .pad_slew(ps)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic priv);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_priv = priv; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_priv = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic priv, output logic [31:0] d);
        bus_addr = a; bus_priv = priv; bus_sel = 1'b1;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic int exp_idx(input logic [7:0] lane);
        int n;
        int k;
        n = 0; k = 0;
        for (int b = 0; b < SEL_W; b++) if (lane[b]) begin n++; k = b; end
        return (n == 1) ? k : 0;
    endfunction

    task automatic chk_pads(input string req);
        for (int p = 0; p < NP; p++) begin
            logic [7:0] lane;
            int k;
            lane = model[p/4][(p%4)*8 +: 8];
            k = exp_idx(lane);
            chk(req, {28'b0, pd[p], po[p], pdr[p], ps[p]},
                {28'b0, fd[p*SEL_W+k], fo[p*SEL_W+k], fdr[p*SEL_W+k], fs[p*SEL_W+k]});
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        for (int r = 0; r < NUM_REGS; r++) model[r] = 32'h0101_0101;
        fd = 24'h5A3C96; fo = 24'hC3A50F; fdr = 24'h0FF0A5; fs = 24'h936C1E;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int r = 0; r < NUM_REGS; r++) begin
            rd(4'(4 + r), 1'b0, d); chk("R1 select reset", d, 32'h0101_0101);
        end
        rd(4'd0, 1'b0, d); chk("R1 key0 reset", d, 0);
        rd(4'd2, 1'b0, d); chk("R1 status reset", d, 0);
        chk("R1 err_pulse reset", {31'b0, err_pulse}, 0);
        chk_pads("R1 default pads");

        // R7/R9 locked privileged write
        wr(4'd4, 32'h0202_0202, 1'b1);
        chk("R9 pulse after locked write", {31'b0, err_pulse}, 1);
        rd(4'd4, 1'b1, d); chk("R7 locked write ignored", d, 32'h0101_0101);
        rd(4'd2, 1'b1, d); chk("R9 sticky set", d, 1);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'b0, err_pulse}, 0);
        wr(4'd2, 32'h0, 1'b1);
        rd(4'd2, 1'b1, d); chk("R10 write 0 keeps status", d, 1);
        wr(4'd2, 32'h1, 1'b0);
        rd(4'd2, 1'b1, d); chk("R8 user clear ignored", d, 1);
        wr(4'd2, 32'h1, 1'b1);
        rd(4'd2, 1'b1, d); chk("R10 clear by writing 1", d, 0);

        // R8 user-mode key writes
        wr(4'd0, K0, 1'b0);
        chk("R8 user write pulses error", {31'b0, err_pulse}, 1);
        wr(4'd1, K1, 1'b0);
        rd(4'd0, 1'b0, d); chk("R8 user key0 ignored", d, 0);
        rd(4'd1, 1'b0, d); chk("R8 user key1 ignored", d, 0);
        wr(4'd2, 32'h1, 1'b1);

        // R7 unlock
        wr(4'd0, K0, 1'b1);
        wr(4'd1, K1, 1'b1);
        rd(4'd1, 1'b0, d); chk("R11 key1 readback user mode", d, K1);
        wr(4'd5, 32'h0401_0204, 1'b0);
        rd(4'd5, 1'b1, d); chk("R8 user mux write ignored", d, 32'h0101_0101);
        rd(4'd2, 1'b1, d); chk("R9 user write sets status", d, 1);
        wr(4'd2, 32'h1, 1'b1);

        // R2..R6 sweep, two input patterns
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) begin fd = ~fd; fo = fo ^ 24'h3C3C3C; fdr = ~fdr; fs = fs ^ 24'hFF0000; end
            for (int p = 0; p < NP; p++) begin
                for (int v = 0; v < 256; v++) begin
                    logic [31:0] w;
                    w = model[p/4];
                    w[(p%4)*8 +: 8] = 8'(v);
                    wr(4'(4 + p/4), w, 1'b1);
                    model[p/4] = w & 32'h0707_0707;
                    chk("R9 no error on unlocked write", {31'b0, err_pulse}, 0);
                    rd(4'(4 + p/4), 1'b0, d);
                    chk("R6 unused bits read zero", d, model[p/4]);
                    chk_pads("R2 R3 R4 R5 pad selection");
                end
                model[p/4][(p%4)*8 +: 8] = 8'h01;
                wr(4'(4 + p/4), model[p/4], 1'b1);
            end
        end

        // R7 relock
        wr(4'd1, 32'h0, 1'b1);
        wr(4'd4, 32'h0404_0404, 1'b1);
        rd(4'd4, 1'b1, d); chk("R7 relocked write ignored", d, model[0]);
        rd(4'd2, 1'b1, d); chk("R9 relocked write flagged", d, 1);
        rd(4'd3, 1'b1, d); chk("R11 unmapped reads zero", d, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule